// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block sits on the host side of a raw 8-bit NAND flash bus. It takes one request at a time, either a page read, a page program or a block erase. It turns that request into the exact series of bus cycles the flash expects: a command byte, the address bytes, any data bytes and a confirm byte. It then waits for the device to finish its internal work and ends by reading the device status.

A request carries an operation code, a 16-bit column, a 24-bit row and a byte count. Program data arrives on a show-ahead byte input: the sequencer drives the byte presented on `wr_data` and pulses `wr_take` once that byte has been written. Read data leaves as single-cycle `rd_valid` pulses. The write strobe and the read strobe each stay low for `T_LO` clock cycles and high for `T_HI` clock cycles.

After the confirm byte the sequencer ignores the ready/busy line for `T_WB` cycles. It then waits for the synchronised line to show ready. If the device stays busy for `BUSY_MAX` cycles, the operation is abandoned with a timeout flag.

The control is one state machine with these states:
- IDLE: waits for a request.
- CMD: sends the opening opcode.
- ADDR: sends the address bytes.
- WDATA: sends the program data.
- CONF: sends the confirm opcode.
- BUSY: waits on ready/busy.
- RDATA: clocks out the read data.
- SCMD: sends the status opcode.
- SREAD: reads the status byte.
- DONE: signals the end of the operation for one cycle.

Its transitions are:
- IDLE→CMD when a valid request is taken.
- CMD→ADDR at the end of the opcode cycle.
- ADDR→WDATA when the last address byte ends on a program with a nonzero count.
- ADDR→CONF when the last address byte ends in every other case.
- WDATA→CONF after the last data byte.
- CONF→BUSY at the end of the confirm cycle.
- BUSY→RDATA when the device is ready on a read with a nonzero count.
- BUSY→SCMD when the device is ready in every other case.
- BUSY→DONE on timeout.
- RDATA→SCMD after the last read byte.
- SCMD→SREAD at the end of the status opcode cycle.
- SREAD→DONE at the end of the status read.
- DONE→IDLE always.

Top module: `nand_op_sequencer`

## Requirements
- R1: After reset, `nf_ce_n`, `nf_we_n` and `nf_re_n` are high, `nf_cle`, `nf_ale` and `nf_wp_n` are low, and `req_ready` is high.
- R2: A read (`req_op`=0) writes the following bytes in order: command 00h; column bits 7:0; column bits 15:8; row bits 7:0; row bits 15:8; row bits 23:16; command 30h.
- R3: A program (`req_op`=1) writes command 80h, then the same five address bytes as a read, then `req_len` data bytes taken from `wr_data`, then command 10h. `wr_take` pulses once per data byte.
- R4: An erase (`req_op`=2) writes command 60h, then the three row bytes from bit 0 upward, then command D0h. No column byte is sent.
- R5: A byte is latched as a command when CLE is high at the rising WE# edge, and as an address when ALE is high at that edge. CLE and ALE are never high together. WE# and RE# go low only while CE# is low.
- R6: Every WE# or RE# low phase lasts exactly `T_LO` cycles. Consecutive strobes are separated by at least `T_HI` high cycles, and WE# and RE# are never low together.
- R7: After the confirm byte, RE# stays high while ready/busy reads busy. A read then returns `req_len` bytes on `rd_valid`, in device order, one per RE# pulse.
- R8: Every operation that does not time out ends with command 70h and one status byte read. `op_fail` equals bit 0 of that status byte.
- R9: `nf_wp_n` is high only while a program or an erase holds CE# low. It is low during reads and while idle.
- R10: If ready/busy does not show ready within `BUSY_MAX` cycles of entering BUSY, `op_timeout` is set, no status command is sent, and the operation ends with `op_done`.
- R11: A program or read with `req_len`=0 has no data cycles: the confirm follows the address for a program, and the status command follows the wait for a read.
- R12: A request with `req_op`=3 is ignored: CE# stays high and `req_ready` stays high.
- R13: `req_ready` is high only in IDLE. A request is taken only while `req_ready` is high, and `req_ready` returns the cycle after `op_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| req_col | input | 8*COL_BYTES | Column address |
| req_row | input | 8*ROW_BYTES | Row address |
| req_len | input | LEN_W | Data byte count |
| req_ready | output | 1 | Sequencer idle, request accepted |
| wr_data | input | 8 | Show-ahead program byte |
| wr_take | output | 1 | Current program byte consumed |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte valid |
| op_done | output | 1 | Operation finished (one cycle) |
| op_fail | output | 1 | Status bit 0 of the last operation |
| op_timeout | output | 1 | Last operation hit the busy timeout |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_wp_n | output | 1 | Write protect, active low |
| nf_io_out | output | 8 | Bus byte driven to the device |
| nf_io_oe | output | 1 | Bus driver enable |
| nf_io_in | input | 8 | Bus byte from the device |
| nf_rb_n | input | 1 | Ready (high) / busy (low) |

## Verification
A state or byte index that drifts shows up at the device side within one bus cycle:
- a wrong opcode, address byte or latch line is seen at the very next rising WE# edge;
- a wrong strobe width is seen at the end of that same low phase.
A missed busy wait appears as an RE# pulse while ready/busy is low. A skipped or extra phase changes the logged byte series, the data count or the flags presented at `op_done`.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_WDATA,
        S_CONF,
        S_BUSY,
        S_RDATA,
        S_SCMD,
        S_SREAD,
        S_DONE
    } seq_state_e;

    localparam logic [7:0] OPC_READ_SETUP  = 8'h00;
    localparam logic [7:0] OPC_READ_GO     = 8'h30;
    localparam logic [7:0] OPC_PROG_SETUP  = 8'h80;
    localparam logic [7:0] OPC_PROG_GO     = 8'h10;
    localparam logic [7:0] OPC_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OPC_STATUS      = 8'h70;

endpackage

// File: rtl/nseq_phase_timer.sv
module nseq_phase_timer #(
    parameter int T_LO = 2,
    parameter int T_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe_low,
    output logic sample,
    output logic last
);
    localparam int TOT = T_LO + T_HI;
    localparam int CW  = $clog2(TOT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign last       = run && (cnt == CW'(TOT - 1));
    assign strobe_low = run && (cnt < CW'(T_LO));
    assign sample     = run && (cnt == CW'(T_LO - 1));

endmodule

// File: rtl/nseq_addr_frame.sv
module nseq_addr_frame #(
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3,
    parameter int IDX_W     = 12
) (
    input  logic [8*COL_BYTES-1:0] col,
    input  logic [8*ROW_BYTES-1:0] row,
    input  logic                   row_only,
    input  logic [IDX_W-1:0]       idx,
    output logic [7:0]             byte_out,
    output logic [IDX_W-1:0]       frame_len
);
    localparam int FULL = COL_BYTES + ROW_BYTES;

    logic [7:0] full_b [FULL];
    logic [7:0] row_b  [ROW_BYTES];

    generate
        for (genvar g = 0; g < COL_BYTES; g++) begin : g_col
            assign full_b[g] = col[8*g +: 8];
        end
        for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
            assign full_b[COL_BYTES + g] = row[8*g +: 8];
            assign row_b[g]              = row[8*g +: 8];
        end
    endgenerate

    always_comb begin
        byte_out = 8'h00;
        for (int k = 0; k < FULL; k++)
            if (!row_only && idx == IDX_W'(k)) byte_out = full_b[k];
        for (int k = 0; k < ROW_BYTES; k++)
            if (row_only && idx == IDX_W'(k)) byte_out = row_b[k];
    end

    assign frame_len = row_only ? IDX_W'(ROW_BYTES) : IDX_W'(FULL);

endmodule

// File: rtl/nseq_busy_watch.sv
module nseq_busy_watch #(
    parameter int T_WB     = 4,
    parameter int BUSY_MAX = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rb_n,
    output logic ready,
    output logic expired
);
    localparam int LIM = (BUSY_MAX > T_WB) ? BUSY_MAX : T_WB + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic [1:0]    rb_sync;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rb_sync <= 2'b00;
        else
            rb_sync <= {rb_sync[0], rb_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!arm)
            cnt <= '0;
        else if (cnt != CW'(LIM))
            cnt <= cnt + CW'(1);
    end

    assign ready   = arm && (cnt >= CW'(T_WB)) && rb_sync[1];
    assign expired = arm && !ready && (cnt == CW'(LIM));

endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
    import nand_seq_pkg::*;
#(
    parameter int T_LO      = 2,
    parameter int T_HI      = 2,
    parameter int T_WB      = 4,
    parameter int BUSY_MAX  = 2000,
    parameter int LEN_W     = 12,
    parameter int COL_BYTES = 2,
    parameter int ROW_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [8*COL_BYTES-1:0] req_col,
    input  logic [8*ROW_BYTES-1:0] req_row,
    input  logic [LEN_W-1:0]       req_len,
    output logic                   req_ready,
    input  logic [7:0]             wr_data,
    output logic                   wr_take,
    output logic [7:0]             rd_data,
    output logic                   rd_valid,
    output logic                   op_done,
    output logic                   op_fail,
    output logic                   op_timeout,
    output logic                   nf_ce_n,
    output logic                   nf_cle,
    output logic                   nf_ale,
    output logic                   nf_we_n,
    output logic                   nf_re_n,
    output logic                   nf_wp_n,
    output logic [7:0]             nf_io_out,
    output logic                   nf_io_oe,
    input  logic [7:0]             nf_io_in,
    input  logic                   nf_rb_n
);
    localparam int CW = 8 * COL_BYTES;
    localparam int RW = 8 * ROW_BYTES;

    seq_state_e state, state_nx;
    op_e              op_q;
    logic [CW-1:0]    col_q;
    logic [RW-1:0]    row_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx;
    logic             fail_q, tout_q;
    logic [7:0]       rd_data_q;
    logic             rd_valid_q;

    logic tm_run, tm_low, tm_sample, tm_last;
    logic bw_ready, bw_expired;
    logic [7:0]       addr_byte;
    logic [LEN_W-1:0] addr_len;
    logic accept, addr_end, data_end;
    logic [7:0] setup_opc, go_opc;

    assign accept   = (state == S_IDLE) && req_valid && (op_e'(req_op) != OP_RSVD);
    assign addr_end = (idx == addr_len - LEN_W'(1));
    assign data_end = (idx == len_q - LEN_W'(1));

    assign tm_run = (state == S_CMD)   || (state == S_ADDR)  || (state == S_WDATA) ||
                    (state == S_CONF)  || (state == S_RDATA) || (state == S_SCMD)  ||
                    (state == S_SREAD);

    nseq_phase_timer #(.T_LO(T_LO), .T_HI(T_HI)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tm_run),
        .strobe_low (tm_low),
        .sample     (tm_sample),
        .last       (tm_last)
    );

    nseq_addr_frame #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES), .IDX_W(LEN_W)) frame_i (
        .col       (col_q),
        .row       (row_q),
        .row_only  (op_q == OP_ERASE),
        .idx       (idx),
        .byte_out  (addr_byte),
        .frame_len (addr_len)
    );

    nseq_busy_watch #(.T_WB(T_WB), .BUSY_MAX(BUSY_MAX)) busy_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state == S_BUSY),
        .rb_n    (nf_rb_n),
        .ready   (bw_ready),
        .expired (bw_expired)
    );

    always_comb begin
        unique case (op_q)
            OP_PROG:  begin setup_opc = OPC_PROG_SETUP;  go_opc = OPC_PROG_GO;  end
            OP_ERASE: begin setup_opc = OPC_ERASE_SETUP; go_opc = OPC_ERASE_GO; end
            default:  begin setup_opc = OPC_READ_SETUP;  go_opc = OPC_READ_GO;  end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept) state_nx = S_CMD;
            S_CMD:   if (tm_last) state_nx = S_ADDR;
            S_ADDR:  if (tm_last && addr_end)
                         state_nx = (op_q == OP_PROG && len_q != '0) ? S_WDATA : S_CONF;
            S_WDATA: if (tm_last && data_end) state_nx = S_CONF;
            S_CONF:  if (tm_last) state_nx = S_BUSY;
            S_BUSY:  begin
                if (bw_ready)
                    state_nx = (op_q == OP_READ && len_q != '0) ? S_RDATA : S_SCMD;
                else if (bw_expired)
                    state_nx = S_DONE;
            end
            S_RDATA: if (tm_last && data_end) state_nx = S_SCMD;
            S_SCMD:  if (tm_last) state_nx = S_SREAD;
            S_SREAD: if (tm_last) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Request latch, byte index, captured data and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_READ;
            col_q      <= '0;
            row_q      <= '0;
            len_q      <= '0;
            idx        <= '0;
            fail_q     <= 1'b0;
            tout_q     <= 1'b0;
            rd_data_q  <= 8'h00;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            if (accept) begin
                op_q   <= op_e'(req_op);
                col_q  <= req_col;
                row_q  <= req_row;
                len_q  <= req_len;
                idx    <= '0;
                fail_q <= 1'b0;
                tout_q <= 1'b0;
            end
            if (state == S_ADDR && tm_last)
                idx <= addr_end ? '0 : idx + LEN_W'(1);
            if ((state == S_WDATA || state == S_RDATA) && tm_last)
                idx <= idx + LEN_W'(1);
            if (state == S_BUSY)
                idx <= '0;
            if (state == S_RDATA && tm_sample) begin
                rd_data_q  <= nf_io_in;
                rd_valid_q <= 1'b1;
            end
            if (state == S_SREAD && tm_sample)
                fail_q <= nf_io_in[0];
            if (state == S_BUSY && bw_expired)
                tout_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        nf_ce_n   = 1'b0;
        nf_cle    = 1'b0;
        nf_ale    = 1'b0;
        nf_we_n   = 1'b1;
        nf_re_n   = 1'b1;
        nf_io_out = 8'h00;
        nf_io_oe  = 1'b0;
        unique case (state)
            S_IDLE, S_DONE: nf_ce_n = 1'b1;
            S_CMD:   begin nf_cle = 1'b1; nf_we_n = !tm_low; nf_io_out = setup_opc;  nf_io_oe = 1'b1; end
            S_ADDR:  begin nf_ale = 1'b1; nf_we_n = !tm_low; nf_io_out = addr_byte;  nf_io_oe = 1'b1; end
            S_WDATA: begin               nf_we_n = !tm_low; nf_io_out = wr_data;    nf_io_oe = 1'b1; end
            S_CONF:  begin nf_cle = 1'b1; nf_we_n = !tm_low; nf_io_out = go_opc;     nf_io_oe = 1'b1; end
            S_SCMD:  begin nf_cle = 1'b1; nf_we_n = !tm_low; nf_io_out = OPC_STATUS; nf_io_oe = 1'b1; end
            S_RDATA, S_SREAD: nf_re_n = !tm_low;
            S_BUSY:  ;
            default: nf_ce_n = 1'b1;
        endcase
        nf_wp_n    = !nf_ce_n && (op_q != OP_READ);
        req_ready  = (state == S_IDLE);
        op_done    = (state == S_DONE);
        wr_take    = (state == S_WDATA) && tm_last;
        rd_data    = rd_data_q;
        rd_valid   = rd_valid_q;
        op_fail    = fail_q;
        op_timeout = tout_q;
    end

endmodule

// File: rtl/nand_op_sequencer_chk.sv
module nand_op_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [1:0] req_op,
    input logic       req_ready,
    input logic       op_done,
    input logic       nf_ce_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic       nf_wp_n
);
    assert_strobe_under_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

    assert_latch_lines_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    assert_strobes_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    assert_wp_low_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nf_ce_n |-> !nf_wp_n);

    assert_reserved_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_op == 2'd3) |=> (req_ready && nf_ce_n));

    assert_accept_starts_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_op != 2'd3) |=> (!nf_ce_n && !req_ready));

    assert_ready_after_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> req_ready);

endmodule

bind nand_op_sequencer nand_op_sequencer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .op_done   (op_done),
    .nf_ce_n   (nf_ce_n),
    .nf_cle    (nf_cle),
    .nf_ale    (nf_ale),
    .nf_we_n   (nf_we_n),
    .nf_re_n   (nf_re_n),
    .nf_wp_n   (nf_wp_n)
);

// File: tb/nand_op_sequencer_tb_top.sv
module nand_op_sequencer_tb_top;
    localparam int T_LO = 2, T_HI = 2, T_WB = 4, BUSY_MAX = 300, LEN_W = 12;
    localparam int BUSY_CYC = 20;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic req_valid;
    logic [1:0] req_op;
    logic [15:0] req_col;
    logic [23:0] req_row;
    logic [LEN_W-1:0] req_len;
    logic req_ready;
    logic [7:0] wr_data;
    logic wr_take;
    logic [7:0] rd_data;
    logic rd_valid, op_done, op_fail, op_timeout;
    logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_wp_n, nf_io_oe;
    logic [7:0] nf_io_out, nf_io_in;
    logic nf_rb_n;

    nand_op_sequencer #(.T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB), .BUSY_MAX(BUSY_MAX),
                        .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_col(req_col), .req_row(req_row), .req_len(req_len), .req_ready(req_ready),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .op_done(op_done), .op_fail(op_fail), .op_timeout(op_timeout),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
        .nf_re_n(nf_re_n), .nf_wp_n(nf_wp_n), .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe),
        .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
    );

    // Behavioural device and bench state (all written by the single initial process)
    int n_tests = 0, n_fail = 0, cyc = 0;
    bit wd_hit = 0;
    logic [9:0] got[$];
    logic [7:0] rd_got[$];
    logic [7:0] wr_q[$];
    int take_cnt = 0;
    logic [7:0] status_val = 8'h00;
    bit stuck = 0;
    int busy_left = 0;
    int mode = 0;
    int ptr = 0;
    bit exp_wp = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    int low_run = 0, high_run = 0;
    bit seen_rise = 0;

    function automatic logic [7:0] page_byte(int i);
        return 8'((8'h3C + i * 29) & 8'hFF);
    endfunction

    assign nf_io_in = (mode == 2) ? status_val : page_byte(ptr);
    assign nf_rb_n  = !(stuck || busy_left > 0);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock of the reference: device model and per-cycle protocol compare
    task automatic tick();
        logic strobe;
        @(negedge clk);
        cyc++;
        if (cyc > 150000) wd_hit = 1;
        if (rst_n) begin
            strobe = nf_we_n & nf_re_n;
            if (!nf_we_n || !nf_re_n) chk(!nf_ce_n, "R5 strobe without CE#", nf_ce_n, 0);
            chk(!(nf_cle && nf_ale), "R5 CLE and ALE together", {nf_cle, nf_ale}, 0);
            chk(!(!nf_we_n && !nf_re_n), "R6 WE# and RE# both low", {nf_we_n, nf_re_n}, 3);
            chk(nf_wp_n == (!nf_ce_n && exp_wp), "R9 WP# level", nf_wp_n, !nf_ce_n && exp_wp);
            if (!nf_rb_n && !nf_re_n) chk(0, "R7 RE# while busy", nf_re_n, 1);
            if (!strobe) begin
                if (seen_rise && low_run == 0)
                    chk(high_run >= T_HI, "R6 high gap", high_run, T_HI);
                low_run++;
                high_run = 0;
            end else begin
                if (low_run > 0) begin
                    chk(low_run == T_LO, "R6 low width", low_run, T_LO);
                    seen_rise = 1;
                end
                low_run = 0;
                high_run++;
            end
            if (nf_ce_n) seen_rise = 0;
            if (busy_left > 0) busy_left--;
            if (!prev_we && nf_we_n) begin
                if (nf_cle) begin
                    got.push_back({2'd1, nf_io_out});
                    if (nf_io_out == 8'h70) mode = 2;
                    else if (nf_io_out == 8'h30 || nf_io_out == 8'h10 || nf_io_out == 8'hD0) begin
                        busy_left = BUSY_CYC;
                        mode = (nf_io_out == 8'h30) ? 1 : 0;
                        ptr = 0;
                    end else mode = 0;
                end else if (nf_ale) got.push_back({2'd2, nf_io_out});
                else got.push_back({2'd3, nf_io_out});
            end
            if (!prev_re && nf_re_n && mode == 1) ptr++;
            if (wr_take) begin
                take_cnt++;
                if (wr_q.size() > 0) void'(wr_q.pop_front());
            end
            if (rd_valid) rd_got.push_back(rd_data);
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
        wr_data = (wr_q.size() > 0) ? wr_q[0] : 8'hEE;
    endtask

    task automatic run_op(input int op, input logic [15:0] col, input logic [23:0] row,
                          input int len, input logic [7:0] stat, input bit hang, input string tag);
        logic [9:0] exp_q[$];
        got.delete(); rd_got.delete(); wr_q.delete(); take_cnt = 0;
        status_val = stat; stuck = hang; exp_wp = (op != 0);
        case (op)
            0: exp_q.push_back({2'd1, 8'h00});
            1: exp_q.push_back({2'd1, 8'h80});
            default: exp_q.push_back({2'd1, 8'h60});
        endcase
        if (op != 2) begin
            exp_q.push_back({2'd2, col[7:0]});
            exp_q.push_back({2'd2, col[15:8]});
        end
        exp_q.push_back({2'd2, row[7:0]});
        exp_q.push_back({2'd2, row[15:8]});
        exp_q.push_back({2'd2, row[23:16]});
        if (op == 1)
            for (int i = 0; i < len; i++) begin
                wr_q.push_back(8'((8'h5A + i * 3) & 8'hFF));
                exp_q.push_back({2'd3, 8'((8'h5A + i * 3) & 8'hFF)});
            end
        case (op)
            0: exp_q.push_back({2'd1, 8'h30});
            1: exp_q.push_back({2'd1, 8'h10});
            default: exp_q.push_back({2'd1, 8'hD0});
        endcase
        if (!hang) exp_q.push_back({2'd1, 8'h70});
        wr_data = (wr_q.size() > 0) ? wr_q[0] : 8'hEE;
        req_op = 2'(op); req_col = col; req_row = row; req_len = LEN_W'(len);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        chk(!nf_ce_n, {tag, " R13 request taken"}, nf_ce_n, 0);
        chk(!req_ready, {tag, " R13 ready low while busy"}, req_ready, 0);
        while (!op_done && !wd_hit) tick();
        chk(op_timeout == hang, {tag, " R10 timeout flag"}, op_timeout, hang);
        chk(op_fail == (hang ? 1'b0 : stat[0]), {tag, " R8 fail flag"}, op_fail,
            hang ? 0 : stat[0]);
        tick();
        chk(req_ready, {tag, " R13 ready after done"}, req_ready, 1);
        chk(got.size() == exp_q.size(), {tag, " byte count on bus"}, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            chk(got[i] == exp_q[i], $sformatf("%s bus byte %0d (kind,value)", tag, i),
                got[i], exp_q[i]);
        if (op == 0 && !hang) begin
            chk(rd_got.size() == len, {tag, " R7 read byte count"}, rd_got.size(), len);
            for (int i = 0; i < len && i < rd_got.size(); i++)
                chk(rd_got[i] == page_byte(i), $sformatf("%s R7 read byte %0d", tag, i),
                    rd_got[i], page_byte(i));
        end
        if (op == 1)
            chk(take_cnt == len, {tag, " R3 wr_take count"}, take_cnt, len);
        stuck = 0; busy_left = 0; exp_wp = 0;
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_col = '0; req_row = '0;
        req_len = '0; wr_data = 8'hEE;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes idle high",
            {nf_ce_n, nf_we_n, nf_re_n}, 7);
        chk(!nf_cle && !nf_ale && !nf_wp_n, "R1 CLE/ALE/WP# low",
            {nf_cle, nf_ale, nf_wp_n}, 0);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        run_op(0, 16'h1234, 24'h56789A, 4, 8'hE0, 0, "R2 read");
        run_op(1, 16'h0407, 24'h00C1F2, 3, 8'hE0, 0, "R3 program");
        run_op(2, 16'hFFFF, 24'hAB12CD, 0, 8'hE1, 0, "R4 erase R8 fail");
        run_op(1, 16'h0020, 24'h000001, 0, 8'hE0, 0, "R11 program len0");
        run_op(0, 16'h0800, 24'h000003, 0, 8'hE0, 0, "R11 read len0");

        // R12 reserved code ignored
        got.delete();
        req_op = 2'd3; req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(nf_ce_n && req_ready, "R12 reserved op ignored", {nf_ce_n, req_ready}, 3);
        end
        req_valid = 1'b0;
        tick();
        chk(got.size() == 0, "R12 no bus cycles", got.size(), 0);

        run_op(2, 16'h0000, 24'h3F0102, 0, 8'hE0, 1, "R10 erase timeout");
        run_op(0, 16'h0001, 24'h000010, 2, 8'hE0, 0, "R10 read after timeout");

        if (wd_hit) chk(0, "watchdog", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule